// File: doc/BRIEF.md
# Latched Serial-to-Parallel Driver Stage

This block takes a serial bit stream and presents it as a parallel word of driver-enable lines. Bits enter on a shift clock and move through a shift register. A separate storage clock copies the whole shift register into a holding register in a single step, so the parallel lines change all at once and not bit by bit during loading. An active-low output enable can switch every line off without touching the stored word. An active-low clear empties both registers at once.

Each parallel line stands for a low-side power switch: 1 turns the switch on so it sinks load current, and 0 turns it off. The block has no current limiting, clamping or analog stage.

Stages chain by wiring one stage's cascade output to the next stage's serial input, with all stages sharing the shift clock, storage clock, clear and enable. The cascade output changes on the falling edge of the shift clock. That gives the next stage half a period of hold margin against clock skew. The serial and clock pins are plain level inputs with no handshake, because each edge of the shift clock accepts exactly one bit. Loading a chain of N stages takes WIDTH×N shift pulses and then one storage pulse.

Top module: `latched_sipo_driver`

## Requirements
- R1: On each rising edge of `shift_clk` (with `clear_n` high), every shift-register bit i moves to bit i+1 and `ser_in` enters bit 0. After WIDTH pulses, the first bit shifted in sits in bit WIDTH-1.
- R2: On each rising edge of `store_clk`, the storage register copies all WIDTH shift-register bits at once. Shift pulses without a storage pulse leave `drv_on` unchanged.
- R3: While `clear_n` is 0, the shift register, the storage register and `cascade_out` are 0 at once, without any clock edge. Clock edges during clear have no effect. The first rising `shift_clk` edge after release shifts normally.
- R4: While `out_en_n` is 1, every bit of `drv_on` is 0 (driver off), whatever the storage register holds.
- R5: While `out_en_n` is 0, `drv_on[i]` equals storage bit i, with 1 meaning the driver is on.
- R6: `cascade_out` changes only on the falling edge of `shift_clk`, where it takes the value of shift-register bit WIDTH-1. A rising edge leaves it unchanged.
- R7: When `shift_clk` and `store_clk` rise together, the storage register captures the shift-register contents from before that shift.
- R8: In a chain of two stages, 2×WIDTH shift pulses followed by one storage pulse put the first bit shifted in at bit WIDTH-1 of the far stage. The concatenation {far, near} then equals the shifted word, taken most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_in | input | 1 | Serial data, sampled on rising `shift_clk` |
| shift_clk | input | 1 | Shift clock; rising edge shifts, falling edge updates `cascade_out` |
| store_clk | input | 1 | Storage clock; rising edge copies the shift register |
| clear_n | input | 1 | Asynchronous active-low clear of all registers |
| out_en_n | input | 1 | Active-low output enable; high forces all drivers off |
| drv_on | output | WIDTH | Driver-on lines, 1 = sinking current |
| cascade_out | output | 1 | Serial output toward the next stage |

## Verification
The bench loads every one of the 256 byte values into an 8-bit stage. Each value is checked at the parallel outputs, at the cascade output and at the downstream stage, which must hold the previous value. A wrong bit order, a wrong shift direction or a missing storage copy shows up here. Walking-one patterns across a 16-bit, two-stage chain show whether each position lands in the right stage. A mixed word checks the position of the first bit shifted in. Directed sequences cover the remaining cases: shifting without a storage pulse, toggling the enable, a clear asserted between clock edges, and simultaneous shift and storage edges. Sampling between the rising and falling halves of a shift pulse tells a falling-edge cascade apart from a rising-edge one.

// File: rtl/sipo_drv_pkg.sv
package sipo_drv_pkg;
  localparam int unsigned STAGE_BITS = 8;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             shift_clk,
  input  logic             clear_n,
  input  logic             ser_in,
  output logic [WIDTH-1:0] shift_q
);
  logic [WIDTH:0] feed;
  assign feed[0] = ser_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign feed[i+1] = shift_q[i];
    always_ff @(posedge shift_clk or negedge clear_n) begin
      if (!clear_n) shift_q[i] <= 1'b0;
      else          shift_q[i] <= feed[i];
    end
  end
endmodule

// File: rtl/sipo_cascade_flop.sv
module sipo_cascade_flop (
  input  logic shift_clk,
  input  logic clear_n,
  input  logic top_bit,
  output logic cascade_out
);
  always_ff @(negedge shift_clk or negedge clear_n) begin
    if (!clear_n) cascade_out <= 1'b0;
    else          cascade_out <= top_bit;
  end
endmodule

// File: rtl/sipo_hold_latch.sv
module sipo_hold_latch #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             store_clk,
  input  logic             clear_n,
  input  logic [WIDTH-1:0] shift_q,
  output logic [WIDTH-1:0] store_q
);
  always_ff @(posedge store_clk or negedge clear_n) begin
    if (!clear_n) store_q <= '0;
    else          store_q <= shift_q;
  end
endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             out_en_n,
  input  logic [WIDTH-1:0] store_q,
  output logic [WIDTH-1:0] drv_on
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_gate
    assign drv_on[i] = store_q[i] & ~out_en_n;
  end
endmodule

// File: rtl/latched_sipo_driver.sv
module latched_sipo_driver #(
  parameter int unsigned WIDTH = sipo_drv_pkg::STAGE_BITS
) (
  input  logic             ser_in,
  input  logic             shift_clk,
  input  logic             store_clk,
  input  logic             clear_n,
  input  logic             out_en_n,
  output logic [WIDTH-1:0] drv_on,
  output logic             cascade_out
);
  localparam int unsigned TOP = WIDTH - 1;

  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] store_q;

  sipo_shift_chain #(.WIDTH(WIDTH)) u_shift (
    .shift_clk (shift_clk),
    .clear_n   (clear_n),
    .ser_in    (ser_in),
    .shift_q   (shift_q)
  );

  sipo_cascade_flop u_casc (
    .shift_clk   (shift_clk),
    .clear_n     (clear_n),
    .top_bit     (shift_q[TOP]),
    .cascade_out (cascade_out)
  );

  sipo_hold_latch #(.WIDTH(WIDTH)) u_hold (
    .store_clk (store_clk),
    .clear_n   (clear_n),
    .shift_q   (shift_q),
    .store_q   (store_q)
  );

  sipo_out_gate #(.WIDTH(WIDTH)) u_gate (
    .out_en_n (out_en_n),
    .store_q  (store_q),
    .drv_on   (drv_on)
  );
endmodule

// File: rtl/sipo_driver_checker.sv
module sipo_driver_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic             shift_clk,
  input logic             store_clk,
  input logic             clear_n,
  input logic             out_en_n,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] store_q,
  input logic [WIDTH-1:0] drv_on,
  input logic             cascade_out
);
  logic [WIDTH-1:0] prev_shift;

  always_ff @(posedge shift_clk or negedge clear_n) begin
    if (!clear_n) prev_shift <= '0;
    else          prev_shift <= shift_q;
  end

  // R1: contents move up one position per rising shift edge
  assert_shift_up_R1: assert property (@(posedge shift_clk) disable iff (!clear_n)
    shift_q[WIDTH-1:1] == prev_shift[WIDTH-2:0]);

  // R6: between falling and next rising edge, cascade mirrors the top bit
  assert_cascade_R6: assert property (@(posedge shift_clk) disable iff (!clear_n)
    cascade_out == shift_q[WIDTH-1]);

  always @(negedge store_clk) begin
    if (!clear_n) begin
      assert_clear_R3: assert (store_q == '0 && shift_q == '0);
    end
    if (out_en_n) begin
      assert_off_R4: assert (drv_on == '0);
    end else begin
      assert_follow_R5: assert (drv_on == store_q);
    end
  end

  always @(negedge shift_clk) begin
    if (!clear_n) begin
      assert_clear_casc_R3: assert (cascade_out == 1'b0 && shift_q == '0);
    end
  end
endmodule

bind latched_sipo_driver sipo_driver_checker #(.WIDTH(WIDTH)) u_chk (
  .shift_clk   (shift_clk),
  .store_clk   (store_clk),
  .clear_n     (clear_n),
  .out_en_n    (out_en_n),
  .shift_q     (shift_q),
  .store_q     (store_q),
  .drv_on      (drv_on),
  .cascade_out (cascade_out)
);

// File: tb/sim_latched_sipo_driver.sv
module sim_latched_sipo_driver;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic ser_in = 1'b0, shift_clk = 1'b0, store_clk = 1'b0;
  logic clear_n = 1'b0, out_en_n = 1'b0;
  logic [W-1:0] drv0, drv1;
  logic casc0, casc1;
  logic [15:0] word;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  latched_sipo_driver #(.WIDTH(W)) u0 (
    .ser_in(ser_in), .shift_clk(shift_clk), .store_clk(store_clk),
    .clear_n(clear_n), .out_en_n(out_en_n), .drv_on(drv0), .cascade_out(casc0));

  latched_sipo_driver #(.WIDTH(W)) u1 (
    .ser_in(casc0), .shift_clk(shift_clk), .store_clk(store_clk),
    .clear_n(clear_n), .out_en_n(out_en_n), .drv_on(drv1), .cascade_out(casc1));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b;
    #2 shift_clk = 1'b1;
    #2 shift_clk = 1'b0;
    #2;
  endtask

  task automatic pulse_store();
    #1 store_clk = 1'b1;
    #2 store_clk = 1'b0;
    #1;
  endtask

  task automatic load_byte(input logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) shift_bit(v[i]);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 200000 && !done) begin
      tests++;
      fails++;
      $display("FAIL watchdog R1..all actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #10;
    // R3: reset state and clocks ignored during clear
    chk(drv0, 0, "R3 reset drv0");
    chk(casc0, 0, "R3 reset cascade");
    for (int i = 0; i < W; i++) shift_bit(1'b1);
    pulse_store();
    chk(drv0, 0, "R3 clocks during clear");
    chk(casc0, 0, "R3 cascade during clear");
    clear_n = 1'b1;
    #3;

    // R1 R5 R6 R8: every byte value, downstream stage holds the previous one
    for (int v = 0; v < 256; v++) begin
      load_byte(v[7:0]);
      pulse_store();
      chk(drv0, v, "R1 R5 byte sweep");
      chk(casc0, (v >> 7) & 1, "R6 cascade top bit");
      chk(drv1, (v == 0) ? 0 : v - 1, "R8 downstream previous byte");
    end

    // R2: shifting without a storage pulse leaves outputs alone
    load_byte(8'h5A);
    chk(drv0, 8'hFF, "R2 hold while shifting");
    pulse_store();
    chk(drv0, 8'h5A, "R2 parallel copy");

    // R4: enable high forces off
    out_en_n = 1'b1;
    #1;
    chk(drv0, 0, "R4 drv0 off");
    chk(drv1, 0, "R4 drv1 off");
    out_en_n = 1'b0;
    #1;
    chk(drv0, 8'h5A, "R5 enable restored");

    // R6: cascade unchanged on rise, updated on fall (bit6 of 5A is 1)
    ser_in = 1'b0;
    #2 shift_clk = 1'b1;
    #1 chk(casc0, 0, "R6 no change on rising edge");
    #1 shift_clk = 1'b0;
    #1 chk(casc0, 1, "R6 update on falling edge");
    #1;

    // R7: simultaneous edges capture the pre-shift word (B4)
    ser_in = 1'b1;
    #2 shift_clk = 1'b1; store_clk = 1'b1;
    #2 shift_clk = 1'b0; store_clk = 1'b0;
    #2 chk(drv0, 8'hB4, "R7 pre-shift capture");
    pulse_store();
    chk(drv0, 8'h69, "R7 post-shift word");

    // R3: asynchronous clear with no clock, then resume
    clear_n = 1'b0;
    #1;
    chk(drv0, 0, "R3 async clear drv0");
    chk(drv1, 0, "R3 async clear drv1");
    chk(casc0, 0, "R3 async clear cascade");
    clear_n = 1'b1;
    #1;
    pulse_store();
    chk(drv0, 0, "R3 shift register emptied");
    shift_bit(1'b1);
    pulse_store();
    chk(drv0, 1, "R3 first edge after release");

    // R8: two-stage chain, walking one and a mixed word
    for (int k = 0; k <= 16; k++) begin
      word = (k < 16) ? (16'd1 << k) : 16'hA5C3;
      for (int i = 15; i >= 0; i--) shift_bit(word[i]);
      pulse_store();
      chk({drv1, drv0}, word, "R8 chain word");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule